// File: doc/BRIEF.md
# Desktop Input Bus Byte Transceiver

This block sits between a host's versatile interface adapter and a serial desktop input bus, and moves whole bytes between them. The host picks a transaction phase by writing two bits of its port B image, sets the shift direction with one auxiliary-control bit, and then trades one byte per port B write. Outgoing command bytes are collected in a command buffer. Reply bytes come back from a bus-device model through a request/response port and are handed to the host one at a time. An active-low attention bit in port B bit 3, driven by the block, tells the host whether its last byte went through. A one-cycle data-ready pulse goes to the adapter's interrupt-flag logic for every byte that moves.

Bytes only move when the parity of the buffer index matches the phase the host declares. The host alternates between the even and odd phases, so a repeated write in the same phase is refused instead of being counted twice. When the line is quiet in the idle phase, a poll timer periodically asks the device model for unsolicited data. If data arrives, the block presents the first byte as if it were a reply.

Top module: `dbus_xcvr`

## Requirements
- R1: After reset, `pb_o` is 0x3C: phase bits [5:4] at idle (3), attention bit 3 high, bit 2 (clock-chip enable) high, all other bits 0. `sr_o`, `data_rdy_o`, `ovf_o` and `req_valid_o` are all 0.
- R2: On every `pb_wr_i`, `pb_o` bits [7:4] and [2:0] take `pb_wdata_i`. Bit 3 of `pb_o` is owned by the block, and the phase is `pb_wdata_i[5:4]`: 0 new, 1 even, 2 odd, 3 idle.
- R3: With `acr_dir_i`=1 (host shifts out) and phase new, the command index restarts at 0 and `sr_i` is stored as byte 0. The attention bit then goes low and `data_rdy_o` pulses for one cycle.
- R4: With `acr_dir_i`=1, the even phase stores a byte only at an odd index and the odd phase only at an even index. A refused byte leaves the buffer untouched, sets the attention bit high and gives no pulse.
- R5: With `acr_dir_i`=1 and phase idle, the byte is refused: the attention bit goes high and there is no pulse.
- R6: A store when the command buffer already holds DEPTH bytes is dropped. It sets the sticky `ovf_o`, which stays set until reset, sets the attention bit high and gives no pulse.
- R7: With `acr_dir_i`=0 and phase idle while commands are pending, the block raises `req_valid_o` with `req_poll_o`=0. It presents the byte count on `req_len_o` and byte i on `req_bytes_o[8i+7:8i]`, and holds them until `rsp_valid_i`.
- R8: A command response empties the command buffer. With `rsp_err_i`, `sr_o` becomes 0xFF, the pulse fires and the attention bit is high. With length 0, there is no pulse and the attention bit is high. Otherwise byte 0 goes to `sr_o`, the pulse fires, and the attention bit goes low unless the byte is 0x00 or 0xFF.
- R9: With `acr_dir_i`=0, the even phase delivers the next reply byte only at an odd index and the odd phase only at an even index. Each delivery loads `sr_o`, pulses, and drives the attention bit low unless the byte is 0x00 or 0xFF. A parity mismatch gives no pulse and sets the attention bit high.
- R10: An even or odd read after the reply is used up (or when there is none) loads 0x00 into `sr_o`, pulses, and sets the attention bit high.
- R11: With `acr_dir_i`=0, a write in the new phase has no effect on `sr_o` or the pulse, and sets the attention bit high.
- R12: Every POLL_CYCLES cycles, a poll request is issued (`req_poll_o`=1, `req_len_o`=0) if all of these hold: the phase is idle, the attention bit is high, no command is pending and the reply is used up. A poll answer with length above 0 presents byte 0 as in R8; any other answer changes nothing.
- R13: While a request is outstanding, including the cycle its response is taken, `pb_wr_i` updates only the port B bits of R2 and moves no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_wr_i | input | 1 | Host port B write strobe, one transfer event |
| pb_wdata_i | input | 8 | Port B value written by the host |
| acr_dir_i | input | 1 | Shift direction, 1 = host shifts out |
| sr_i | input | 8 | Host shift register contents for output |
| pb_o | output | 8 | Port B image, bit 3 = active-low attention |
| sr_o | output | 8 | Byte delivered into the shift register |
| data_rdy_o | output | 1 | One-cycle pulse per moved byte |
| ovf_o | output | 1 | Sticky command-buffer overflow |
| req_valid_o | output | 1 | Request to the bus-device model |
| req_poll_o | output | 1 | Request is a poll rather than a command |
| req_len_o | output | IDX_W | Pending command byte count |
| req_bytes_o | output | DEPTH*8 | Command bytes, byte 0 lowest |
| rsp_valid_i | input | 1 | Response strobe from the device model |
| rsp_err_i | input | 1 | Response reports a bus error |
| rsp_len_i | input | IDX_W | Reply byte count |
| rsp_bytes_i | input | DEPTH*8 | Reply bytes, byte 0 lowest |

## Verification
The assertions assume the device model answers only while a request is outstanding, and never gives a reply length above DEPTH. The bench's responder answers exactly one cycle after `req_valid_o` rises and draws reply lengths from 0 to DEPTH. Host writes are assumed to arrive only while no request is pending, apart from the single directed R13 case. The bench's host tasks wait for `req_valid_o` to drop before each write, so poll traffic never collides with a transfer.

// File: rtl/dbus_pkg.sv
package dbus_pkg;

    typedef enum logic [1:0] {
        PH_NEW  = 2'd0,
        PH_EVEN = 2'd1,
        PH_ODD  = 2'd2,
        PH_IDLE = 2'd3
    } phase_e;

    localparam int unsigned PB_ATTN_BIT = 3;
    localparam logic [7:0]  PB_RESET    = 8'h3C;

    // reply bytes that never raise attention
    function automatic logic quiet_byte(input logic [7:0] b);
        return (b == 8'h00) || (b == 8'hFF);
    endfunction

endpackage

// File: rtl/dbus_parity_gate.sv
module dbus_parity_gate
    import dbus_pkg::*;
(
    input  phase_e phase_i,
    input  logic   idx_odd_i,
    output logic   ok_o
);
    always_comb begin
        unique case (phase_i)
            PH_NEW:  ok_o = 1'b1;
            PH_EVEN: ok_o = idx_odd_i;
            PH_ODD:  ok_o = !idx_odd_i;
            default: ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbus_poll_timer.sv
module dbus_poll_timer #(
    parameter int unsigned POLL_CYCLES = 4_000_000,
    localparam int unsigned CNT_W = $clog2(POLL_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == CNT_W'(POLL_CYCLES - 1));
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dbus_xcvr.sv
module dbus_xcvr
    import dbus_pkg::*;
#(
    parameter int unsigned DEPTH       = 8,
    parameter int unsigned POLL_CYCLES = 4_000_000,
    localparam int unsigned IDX_W = $clog2(DEPTH + 1),
    localparam int unsigned BUF_W = DEPTH * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pb_wr_i,
    input  logic [7:0]       pb_wdata_i,
    input  logic             acr_dir_i,
    input  logic [7:0]       sr_i,
    output logic [7:0]       pb_o,
    output logic [7:0]       sr_o,
    output logic             data_rdy_o,
    output logic             ovf_o,
    output logic             req_valid_o,
    output logic             req_poll_o,
    output logic [IDX_W-1:0] req_len_o,
    output logic [BUF_W-1:0] req_bytes_o,
    input  logic             rsp_valid_i,
    input  logic             rsp_err_i,
    input  logic [IDX_W-1:0] rsp_len_i,
    input  logic [BUF_W-1:0] rsp_bytes_i
);
    typedef struct packed {
        logic [7:0]       pb;
        logic [7:0]       sr;
        logic             rdy;
        logic             ovf;
        logic             busy;
        logic             poll;
        logic [IDX_W-1:0] out_idx;
        logic [IDX_W-1:0] in_idx;
        logic [IDX_W-1:0] in_size;
        logic [BUF_W-1:0] out_buf;
        logic [BUF_W-1:0] in_buf;
    } st_t;

    st_t st_d, st_q;

    wire    unused_pb3 = pb_wdata_i[PB_ATTN_BIT];
    phase_e wr_ph, cur_ph;
    logic   out_ok, in_ok, poll_tick;
    logic   [7:0] in_byte;
    logic   [IDX_W-1:0] len_eff;
    logic   reply_done;

    assign wr_ph  = phase_e'(pb_wdata_i[5:4]);
    assign cur_ph = phase_e'(st_q.pb[5:4]);

    dbus_parity_gate u_out_gate (.phase_i(wr_ph), .idx_odd_i(st_q.out_idx[0]), .ok_o(out_ok));
    dbus_parity_gate u_in_gate  (.phase_i(wr_ph), .idx_odd_i(st_q.in_idx[0]),  .ok_o(in_ok));
    dbus_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (.clk(clk), .rst_n(rst_n), .tick_o(poll_tick));

    always_comb begin
        in_byte = 8'h00;
        for (int i = 0; i < DEPTH; i++) begin
            if (IDX_W'(i) == st_q.in_idx) in_byte = st_q.in_buf[i*8 +: 8];
        end
        len_eff    = (rsp_len_i > IDX_W'(DEPTH)) ? IDX_W'(DEPTH) : rsp_len_i;
        reply_done = (st_q.in_idx >= st_q.in_size);
    end

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b0;
        if (pb_wr_i) begin
            st_d.pb[7:4] = pb_wdata_i[7:4];
            st_d.pb[2:0] = pb_wdata_i[2:0];
        end
        if (st_q.busy) begin
            if (rsp_valid_i) begin
                st_d.busy = 1'b0;
                if (!st_q.poll) begin
                    st_d.out_idx = '0;
                    st_d.in_idx  = '0;
                    st_d.in_size = '0;
                    st_d.pb[PB_ATTN_BIT] = 1'b1;
                    if (rsp_err_i) begin
                        st_d.sr  = 8'hFF;
                        st_d.rdy = 1'b1;
                    end
                end
                if (!rsp_err_i && len_eff != '0) begin
                    st_d.in_buf  = rsp_bytes_i;
                    st_d.in_size = len_eff;
                    st_d.in_idx  = IDX_W'(1);
                    st_d.sr      = rsp_bytes_i[7:0];
                    st_d.rdy     = 1'b1;
                    st_d.pb[PB_ATTN_BIT] = quiet_byte(rsp_bytes_i[7:0]);
                end
            end
        end else if (pb_wr_i) begin
            st_d.pb[PB_ATTN_BIT] = 1'b1;
            if (acr_dir_i) begin
                if (wr_ph == PH_NEW) begin
                    st_d.out_buf[7:0]    = sr_i;
                    st_d.out_idx         = IDX_W'(1);
                    st_d.rdy             = 1'b1;
                    st_d.pb[PB_ATTN_BIT] = 1'b0;
                end else if (out_ok) begin
                    if (st_q.out_idx == IDX_W'(DEPTH)) begin
                        st_d.ovf = 1'b1;
                    end else begin
                        for (int i = 0; i < DEPTH; i++) begin
                            if (IDX_W'(i) == st_q.out_idx) st_d.out_buf[i*8 +: 8] = sr_i;
                        end
                        st_d.out_idx         = st_q.out_idx + 1'b1;
                        st_d.rdy             = 1'b1;
                        st_d.pb[PB_ATTN_BIT] = 1'b0;
                    end
                end
            end else begin
                unique case (wr_ph)
                    PH_NEW: ;
                    PH_IDLE: begin
                        if (st_q.out_idx != '0) begin
                            st_d.busy = 1'b1;
                            st_d.poll = 1'b0;
                        end
                    end
                    default: begin
                        if (reply_done) begin
                            st_d.sr  = 8'h00;
                            st_d.rdy = 1'b1;
                        end else if (in_ok) begin
                            st_d.sr              = in_byte;
                            st_d.in_idx          = st_q.in_idx + 1'b1;
                            st_d.rdy             = 1'b1;
                            st_d.pb[PB_ATTN_BIT] = quiet_byte(in_byte);
                        end
                    end
                endcase
            end
        end else if (poll_tick && cur_ph == PH_IDLE && st_q.pb[PB_ATTN_BIT]
                     && st_q.out_idx == '0 && reply_done) begin
            st_d.busy = 1'b1;
            st_d.poll = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pb <= PB_RESET;
        end else begin
            st_q    <= st_d;
        end
    end

    assign pb_o        = st_q.pb;
    assign sr_o        = st_q.sr;
    assign data_rdy_o  = st_q.rdy;
    assign ovf_o       = st_q.ovf;
    assign req_valid_o = st_q.busy;
    assign req_poll_o  = st_q.poll;
    assign req_len_o   = st_q.out_idx;
    assign req_bytes_o = st_q.out_buf;

    // attention only drops together with a data-ready pulse
    assert_attn_fall_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pb_o[PB_ATTN_BIT]) |-> data_rdy_o);

    assert_idle_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_wr_i && !req_valid_o && acr_dir_i && pb_wdata_i[5:4] == 2'd3)
        |=> (pb_o[PB_ATTN_BIT] && !data_rdy_o));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_len_o <= IDX_W'(DEPTH));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !rsp_valid_i) |=> (req_valid_o && $stable(req_len_o) && $stable(req_poll_o)));

    assert_new_in_noop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_wr_i && !req_valid_o && !acr_dir_i && pb_wdata_i[5:4] == 2'd0)
        |=> ($stable(sr_o) && !data_rdy_o && pb_o[PB_ATTN_BIT]));

    assert_poll_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_poll_o) |-> (req_len_o == '0));

    assert_busy_no_move_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !rsp_valid_i) |=> !data_rdy_o);

endmodule

// File: tb/dbus_xcvr_tb_top.sv
module dbus_xcvr_tb_top;
    localparam int DEPTH = 8;
    localparam int POLL  = 300;
    localparam int IDX_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pb_wr_i = 1'b0;
    logic [7:0] pb_wdata_i = 8'h00;
    logic acr_dir_i = 1'b0;
    logic [7:0] sr_i = 8'h00;
    logic [7:0] pb_o, sr_o;
    logic data_rdy_o, ovf_o, req_valid_o, req_poll_o;
    logic [IDX_W-1:0] req_len_o;
    logic [DEPTH*8-1:0] req_bytes_o;
    logic rsp_valid_i = 1'b0;
    logic rsp_err_i = 1'b0;
    logic [IDX_W-1:0] rsp_len_i = '0;
    logic [DEPTH*8-1:0] rsp_bytes_i = '0;

    always #2.5 clk = ~clk;

    dbus_xcvr #(.DEPTH(DEPTH), .POLL_CYCLES(POLL)) dut_i (
        .clk(clk), .rst_n(rst_n), .pb_wr_i(pb_wr_i), .pb_wdata_i(pb_wdata_i),
        .acr_dir_i(acr_dir_i), .sr_i(sr_i), .pb_o(pb_o), .sr_o(sr_o),
        .data_rdy_o(data_rdy_o), .ovf_o(ovf_o), .req_valid_o(req_valid_o),
        .req_poll_o(req_poll_o), .req_len_o(req_len_o), .req_bytes_o(req_bytes_o),
        .rsp_valid_i(rsp_valid_i), .rsp_err_i(rsp_err_i), .rsp_len_i(rsp_len_i),
        .rsp_bytes_i(rsp_bytes_i));

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] cmd_b [DEPTH];
    logic [7:0] rep_b [DEPTH];
    logic [7:0] pol_b [DEPTH];
    int rep_len = 0;
    int pol_len = 0;
    bit rep_err = 1'b0;
    int cap_len = 0;
    bit cap_poll = 1'b0;
    logic [DEPTH*8-1:0] cap_bytes = '0;

    function automatic bit exp_attn(input logic [7:0] b);
        return (b == 8'h00) || (b == 8'hFF);
    endfunction

    function automatic logic [1:0] alt_ph(input int k);
        return (k % 2 == 1) ? 2'd1 : 2'd2;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // responder: answers one cycle after a request appears
    initial begin
        forever begin
            @(negedge clk);
            if (req_valid_o) begin
                cap_len   = int'(req_len_o);
                cap_poll  = req_poll_o;
                cap_bytes = req_bytes_o;
                rsp_valid_i = 1'b1;
                if (req_poll_o) begin
                    rsp_err_i = 1'b0;
                    rsp_len_i = IDX_W'(pol_len);
                    for (int i = 0; i < DEPTH; i++) rsp_bytes_i[i*8 +: 8] = pol_b[i];
                end else begin
                    rsp_err_i = rep_err;
                    rsp_len_i = IDX_W'(rep_len);
                    for (int i = 0; i < DEPTH; i++) rsp_bytes_i[i*8 +: 8] = rep_b[i];
                end
            end else begin
                rsp_valid_i = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // one host port B write; returns at the negedge after it is registered
    task automatic hb_event(input logic [1:0] ph, input bit dout, input logic [7:0] b);
        logic [7:0] r;
        while (req_valid_o) @(negedge clk);
        r = 8'($urandom);
        pb_wr_i = 1'b1;
        pb_wdata_i = {r[7:6], ph, r[3], r[2:0]};
        acr_dir_i = dout;
        sr_i = b;
        @(negedge clk);
        pb_wr_i = 1'b0;
        chk("R2 pb upper", int'(pb_o[7:4]), int'({r[7:6], ph}));
        chk("R2 pb lower", int'(pb_o[2:0]), int'(r[2:0]));
    endtask

    task automatic send_cmd(input int n);
        hb_event(2'd0, 1'b1, cmd_b[0]);
        chk("R3 new rdy", int'(data_rdy_o), 1);
        chk("R3 new attn", int'(pb_o[3]), 0);
        for (int k = 1; k < n; k++) begin
            hb_event(alt_ph(k), 1'b1, cmd_b[k]);
            chk("R4 store rdy", int'(data_rdy_o), 1);
            chk("R4 store attn", int'(pb_o[3]), 0);
        end
    endtask

    task automatic issue(input int n);
        logic [7:0] prev;
        prev = sr_o;
        hb_event(2'd3, 1'b0, 8'h00);
        chk("R7 req valid", int'(req_valid_o), 1);
        @(negedge clk);
        chk("R7 req len", cap_len, n);
        chk("R7 req kind", int'(cap_poll), 0);
        for (int i = 0; i < n; i++) chk("R7 req byte", int'(cap_bytes[i*8 +: 8]), int'(cmd_b[i]));
        if (rep_err) begin
            chk("R8 err sr", int'(sr_o), 8'hFF);
            chk("R8 err rdy", int'(data_rdy_o), 1);
            chk("R8 err attn", int'(pb_o[3]), 1);
        end else if (rep_len == 0) begin
            chk("R8 empty sr", int'(sr_o), int'(prev));
            chk("R8 empty rdy", int'(data_rdy_o), 0);
            chk("R8 empty attn", int'(pb_o[3]), 1);
        end else begin
            chk("R8 first sr", int'(sr_o), int'(rep_b[0]));
            chk("R8 first rdy", int'(data_rdy_o), 1);
            chk("R8 first attn", int'(pb_o[3]), int'(exp_attn(rep_b[0])));
        end
    endtask

    task automatic read_rest();
        int eff;
        eff = rep_err ? 0 : rep_len;
        for (int k = 1; k < eff; k++) begin
            hb_event(alt_ph(k), 1'b0, 8'h00);
            chk("R9 read sr", int'(sr_o), int'(rep_b[k]));
            chk("R9 read rdy", int'(data_rdy_o), 1);
            chk("R9 read attn", int'(pb_o[3]), int'(exp_attn(rep_b[k])));
        end
        hb_event(alt_ph(eff < 1 ? 1 : eff), 1'b0, 8'h00);
        chk("R10 done sr", int'(sr_o), 0);
        chk("R10 done rdy", int'(data_rdy_o), 1);
        chk("R10 done attn", int'(pb_o[3]), 1);
    endtask

    task automatic rand_fill();
        for (int i = 0; i < DEPTH; i++) begin
            cmd_b[i] = 8'($urandom);
            rep_b[i] = 8'($urandom);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) pol_b[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pb", int'(pb_o), 8'h3C);
        chk("R1 sr", int'(sr_o), 0);
        chk("R1 rdy", int'(data_rdy_o), 0);
        chk("R1 ovf", int'(ovf_o), 0);
        chk("R1 req", int'(req_valid_o), 0);

        // parity refusals, idle refusal, new-phase input no-op
        rand_fill();
        rep_b[0] = 8'h3A; rep_b[1] = 8'hFF; rep_b[2] = 8'h11;
        rep_len = 3; rep_err = 1'b0;
        hb_event(2'd0, 1'b1, cmd_b[0]);
        hb_event(2'd2, 1'b1, 8'hEE);
        chk("R4 odd refuse rdy", int'(data_rdy_o), 0);
        chk("R4 odd refuse attn", int'(pb_o[3]), 1);
        hb_event(2'd1, 1'b1, cmd_b[1]);
        hb_event(2'd1, 1'b1, 8'hDD);
        chk("R4 repeat refuse rdy", int'(data_rdy_o), 0);
        chk("R4 repeat refuse attn", int'(pb_o[3]), 1);
        hb_event(2'd2, 1'b1, cmd_b[2]);
        hb_event(2'd3, 1'b1, 8'hCC);
        chk("R5 idle refuse rdy", int'(data_rdy_o), 0);
        chk("R5 idle refuse attn", int'(pb_o[3]), 1);
        hb_event(2'd0, 1'b0, 8'h00);
        chk("R11 new input sr", int'(sr_o), 0);
        chk("R11 new input rdy", int'(data_rdy_o), 0);
        chk("R11 new input attn", int'(pb_o[3]), 1);

        // issue with a write colliding with the response cycle
        hb_event(2'd3, 1'b0, 8'h00);
        pb_wr_i = 1'b1;
        pb_wdata_i = 8'h95;
        acr_dir_i = 1'b0;
        @(negedge clk);
        pb_wr_i = 1'b0;
        chk("R7 req len", cap_len, 3);
        chk("R13 busy sr", int'(sr_o), 8'h3A);
        chk("R13 busy pb bits", int'(pb_o[7:4]), 9);
        chk("R13 busy attn", int'(pb_o[3]), 0);
        hb_event(2'd1, 1'b0, 8'h00);
        chk("R13 next byte", int'(sr_o), 8'hFF);
        chk("R9 quiet attn", int'(pb_o[3]), 1);
        hb_event(2'd2, 1'b0, 8'h00);
        chk("R9 third byte", int'(sr_o), 8'h11);
        hb_event(2'd1, 1'b0, 8'h00);
        chk("R10 used up sr", int'(sr_o), 0);
        chk("R10 used up attn", int'(pb_o[3]), 1);
        hb_event(2'd3, 1'b0, 8'h00);
        chk("R8 buffer emptied", int'(req_valid_o), 0);

        // overflow
        rand_fill();
        rep_len = 2; rep_err = 1'b0;
        send_cmd(DEPTH);
        hb_event(alt_ph(DEPTH), 1'b1, 8'h77);
        chk("R6 ovf", int'(ovf_o), 1);
        chk("R6 drop rdy", int'(data_rdy_o), 0);
        chk("R6 drop attn", int'(pb_o[3]), 1);
        issue(DEPTH);
        read_rest();
        chk("R6 ovf sticky", int'(ovf_o), 1);

        // error and empty responses
        rand_fill();
        rep_err = 1'b1; rep_len = 4;
        send_cmd(2); issue(2); read_rest();
        rep_err = 1'b0; rep_len = 0;
        send_cmd(1); issue(1);

        // poll
        pol_b[0] = 8'h5A; pol_b[1] = 8'h00; pol_len = 2;
        hb_event(2'd3, 1'b0, 8'h00);
        chk("R12 quiet idle", int'(data_rdy_o), 0);
        for (int w = 0; w < 3 * POLL && !data_rdy_o; w++) @(negedge clk);
        chk("R12 poll kind", int'(cap_poll), 1);
        chk("R12 poll len", cap_len, 0);
        chk("R12 poll rdy", int'(data_rdy_o), 1);
        chk("R12 poll sr", int'(sr_o), 8'h5A);
        chk("R12 poll attn", int'(pb_o[3]), 0);
        pol_len = 0;
        hb_event(2'd1, 1'b0, 8'h00);
        chk("R12 poll second", int'(sr_o), 8'h00);
        chk("R12 poll second attn", int'(pb_o[3]), 1);

        // constrained random transactions
        for (int t = 0; t < 40; t++) begin
            int n;
            rand_fill();
            n = 1 + int'($urandom_range(DEPTH - 1));
            rep_len = int'($urandom_range(DEPTH));
            rep_err = ($urandom_range(7) == 0);
            if ($urandom_range(3) == 0) rep_b[0] = ($urandom_range(1) == 0) ? 8'h00 : 8'hFF;
            send_cmd(n);
            issue(n);
            read_rest();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule